// File: doc/BRIEF.md
# Radar Frequency Channel Discriminator

This block reduces the detector flags of a receiver front end to a single frequency channel code. The front end has two mixer groups whose heterodyne frequencies interleave. Within a group the local oscillators step by 40 MHz, and the second group sits 20 MHz above the first. The outputs of each group are merged and passed through four filters. The block therefore sees one flag per pairing of mixer group and filter, which is a small matrix. Mixing produces both a sum image and a difference image, so one radar frequency can light two cells of that matrix. A fixed priority table chooses which cell is genuine and which is the image.

A rising edge on the pulse-present strobe opens an evaluation window of `WIN_CYC` clock cycles, timed by a counter. During the window, a flag counts only if it stays high for `MIN_RUN` consecutive samples. This screens out short flickers caused by spectral spreading from short radar pulses. When the window closes, the table entries are searched in order. The first entry that matches drives the channel code and raises a one-cycle valid pulse. If no entry matches, the block raises a one-cycle error pulse and leaves the code unchanged.

Top module: `chan_disc`

## Requirements
- R1: While reset is asserted and after it is released, `code_o` is 0 and `valid_o` and `err_o` are low.
- R2: A window opens when the clock edge samples `pulse_i` high after it was low. Flags are sampled on the `WIN_CYC` following edges. The result is visible after the edge `WIN_CYC+1` cycles after the opening edge, and a result appears only then.
- R3: A new rising edge of `pulse_i` while a window is open or being decided has no effect. A strobe held high does not open a second window.
- R4: A flag qualifies only when it is high on at least `MIN_RUN` consecutive sampling edges inside the window. A shorter run, or two short runs split by a low sample, does not qualify.
- R5: Flag activity before the window opens or after it closes has no effect on the decision.
- R6: Flag bit `g*NUM_FLT+f` is mixer group `g` through filter `f`. Table entries are searched from index 0 upward and the lowest matching index wins. An entry matches when every one of its required flags has qualified and none of its veto flags has qualified.
- R7: In the default table, entry k requires flag k, vetoes flag k XOR 4 (the same filter in the other group, which is the image cell), and carries code k+1.
- R8: On a match, `valid_o` is high for exactly one cycle and `code_o` carries the matched code in that cycle.
- R9: If nothing matches, `err_o` is high for exactly one cycle. `valid_o` stays low, and `valid_o` and `err_o` are never high together.
- R10: `code_o` changes only in a cycle where `valid_o` is high, and otherwise holds the last valid code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Pulse-present strobe; a rising edge opens a window |
| det_i | input | NUM_GRP*NUM_FLT | Per-cycle detector flags, bit g*NUM_FLT+f |
| code_o | output | CODE_W | Discriminated channel code |
| valid_o | output | 1 | One-cycle pulse: new code available |
| err_o | output | 1 | One-cycle pulse: no table entry matched |

## Verification
The assertions assume that the strobe and flags are synchronous to `clk_i` and change only away from its rising edge. They also assume that each decision is followed by a quiet gap before the next strobe edge. The stimulus drives every input on the falling clock edge. It keeps the strobe low for several cycles after each result. Flag runs are placed at known offsets from the opening edge, so the length of each run inside the window is exact. That includes runs that straddle the window boundary on either side.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_DEC  = 2'd2
  } win_st_e;
endpackage

// File: rtl/fcd_win_timer.sv
module fcd_win_timer
  import fcd_pkg::*;
#(
  parameter int WIN_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic win_start_o,
  output logic win_act_o,
  output logic win_done_o
);
  localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

  win_st_e            st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               pulse_q;
  logic               rise;

  assign rise        = pulse_i & ~pulse_q;
  assign win_start_o = (st_q == ST_IDLE) && rise;
  assign win_act_o   = (st_q == ST_WIN);
  assign win_done_o  = (st_q == ST_DEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_i;
      unique case (st_q)
        ST_IDLE: begin
          if (rise) begin
            st_q  <= ST_WIN;
            cnt_q <= '0;
          end
        end
        ST_WIN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(WIN_CYC - 1)) st_q <= ST_DEC;
        end
        ST_DEC:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcd_flag_qual.sv
module fcd_flag_qual #(
  parameter int NFLAG   = 8,
  parameter int MIN_RUN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             act_i,
  input  logic [NFLAG-1:0] det_i,
  output logic [NFLAG-1:0] qual_o
);
  localparam int RUN_W = $clog2(MIN_RUN + 1);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nxt;
    logic             q_q;

    // saturate at the threshold
    assign run_nxt = (run_q == RUN_W'(MIN_RUN)) ? run_q : run_q + 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q <= '0;
        q_q   <= 1'b0;
      end else if (clr_i) begin
        run_q <= '0;
        q_q   <= 1'b0;
      end else if (act_i) begin
        if (det_i[i]) begin
          run_q <= run_nxt;
          if (run_nxt == RUN_W'(MIN_RUN)) q_q <= 1'b1;
        end else begin
          run_q <= '0;
        end
      end
    end

    assign qual_o[i] = q_q;
  end
endmodule

// File: rtl/fcd_prio_sel.sv
module fcd_prio_sel #(
  parameter int                             NFLAG     = 8,
  parameter int                             NUM_ENTRY = 8,
  parameter int                             CODE_W    = 4,
  parameter logic [NUM_ENTRY*NFLAG-1:0]     NEED_TBL  = '0,
  parameter logic [NUM_ENTRY*NFLAG-1:0]     VETO_TBL  = '0,
  parameter logic [NUM_ENTRY*CODE_W-1:0]    CODE_TBL  = '0
) (
  input  logic [NFLAG-1:0]  qual_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NUM_ENTRY-1:0] match;

  for (genvar k = 0; k < NUM_ENTRY; k++) begin : g_ent
    localparam logic [NFLAG-1:0] NEED = NEED_TBL[k*NFLAG +: NFLAG];
    localparam logic [NFLAG-1:0] VETO = VETO_TBL[k*NFLAG +: NFLAG];
    assign match[k] = (NEED != '0) && ((qual_i & NEED) == NEED) && ((qual_i & VETO) == '0);
  end

  // lowest index wins: scan downward so the last write is the winner
  always_comb begin
    hit_o  = 1'b0;
    code_o = '0;
    for (int k = NUM_ENTRY - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o  = 1'b1;
        code_o = CODE_TBL[k*CODE_W +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/chan_disc.sv
module chan_disc #(
  parameter int NUM_GRP   = 2,
  parameter int NUM_FLT   = 4,
  parameter int WIN_CYC   = 300,
  parameter int MIN_RUN   = 4,
  parameter int NUM_ENTRY = 8,
  parameter int CODE_W    = 4,
  parameter logic [NUM_ENTRY*NUM_GRP*NUM_FLT-1:0] NEED_TBL = 64'h8040_2010_0804_0201,
  parameter logic [NUM_ENTRY*NUM_GRP*NUM_FLT-1:0] VETO_TBL = 64'h0804_0201_8040_2010,
  parameter logic [NUM_ENTRY*CODE_W-1:0]          CODE_TBL = 32'h8765_4321
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pulse_i,
  input  logic [NUM_GRP*NUM_FLT-1:0] det_i,
  output logic [CODE_W-1:0]          code_o,
  output logic                       valid_o,
  output logic                       err_o
);
  localparam int NFLAG = NUM_GRP * NUM_FLT;

  logic              win_start;
  logic              win_act;
  logic              win_done;
  logic [NFLAG-1:0]  qual;
  logic              hit;
  logic [CODE_W-1:0] sel_code;

  fcd_win_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_i    (pulse_i),
    .win_start_o(win_start),
    .win_act_o  (win_act),
    .win_done_o (win_done)
  );

  fcd_flag_qual #(.NFLAG(NFLAG), .MIN_RUN(MIN_RUN)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (win_start),
    .act_i (win_act),
    .det_i (det_i),
    .qual_o(qual)
  );

  fcd_prio_sel #(
    .NFLAG    (NFLAG),
    .NUM_ENTRY(NUM_ENTRY),
    .CODE_W   (CODE_W),
    .NEED_TBL (NEED_TBL),
    .VETO_TBL (VETO_TBL),
    .CODE_TBL (CODE_TBL)
  ) u_prio (
    .qual_i(qual),
    .hit_o (hit),
    .code_o(sel_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= win_done & hit;
      err_o   <= win_done & ~hit;
      if (win_done && hit) code_o <= sel_code;
    end
  end
endmodule

// File: rtl/chan_disc_chk.sv
module chan_disc_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_o,
  input logic              err_o,
  input logic [CODE_W-1:0] code_o,
  input logic              win_done
);
  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  assert_code_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(code_o));

  assert_only_after_win_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || err_o) |-> $past(win_done));

  assert_result_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done |=> (valid_o || err_o));
endmodule

bind chan_disc chan_disc_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .err_o   (err_o),
  .code_o  (code_o),
  .win_done(win_done)
);

// File: tb/chan_disc_bench.sv
module chan_disc_bench;
  localparam int W = 300;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pulse = 1'b0;
  logic [7:0] det = '0;
  logic [3:0] code_o;
  logic       valid_o;
  logic       err_o;

  int  cyc = 0;
  int  tests = 0;
  int  fails = 0;
  bit  done = 0;
  logic [3:0] last_code = '0;

  typedef struct {
    bit         is_err;
    logic [3:0] code;
    int         stamp;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chan_disc #(.WIN_CYC(W), .MIN_RUN(N)) u_chan_disc (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .pulse_i(pulse),
    .det_i  (det),
    .code_o (code_o),
    .valid_o(valid_o),
    .err_o  (err_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // sampling edges inside the window are 1..W after the opening edge
  function automatic bit seg_qual(input int s, input int h);
    int hi = (s + h < W + 1) ? s + h : W + 1;
    int lo = (s > 1) ? s : 1;
    return (h > 0) && (hi - lo >= N);
  endfunction

  // R7 default table: entry k needs flag k, vetoes flag k^4, code k+1
  function automatic int ref_code(input logic [7:0] qm);
    for (int k = 0; k < 8; k++)
      if (qm[k] && !qm[k ^ 4]) return k + 1;
    return 0;
  endfunction

  task automatic run_win(input string tag,
                         input int sa, input int ha, input logic [7:0] ma,
                         input int sb, input int hb, input logic [7:0] mb,
                         input int plen, input bit retrig);
    logic [7:0] qm = '0;
    int ec;
    exp_t e;
    if (seg_qual(sa, ha)) qm |= ma;
    if (seg_qual(sb, hb)) qm |= mb;
    ec = ref_code(qm);
    for (int j = 0; j <= W + 3; j++) begin
      @(negedge clk);
      if (j == 0) begin
        e.is_err = (ec == 0);
        e.code   = (ec == 0) ? last_code : 4'(ec);
        e.stamp  = cyc + W + 2;
        e.tag    = tag;
        q.push_back(e);
        if (ec != 0) last_code = 4'(ec);
      end
      pulse = (j < plen) || (retrig && j >= plen + 5 && j < W - 10);
      det = ((j >= sa && j < sa + ha) ? ma : 8'h00) | ((j >= sb && j < sb + hb) ? mb : 8'h00);
    end
    @(negedge clk);
    pulse = 1'b0;
    det = '0;
    repeat (6) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && (valid_o || err_o)) begin
      exp_t e;
      if (q.size() == 0) begin
        chk(0, "R3", "unexpected result", int'(valid_o), 0);
      end else begin
        e = q.pop_front();
        chk(err_o == e.is_err, e.is_err ? "R9" : "R8", {e.tag, " kind err"}, int'(err_o), int'(e.is_err));
        chk(valid_o != err_o, "R9", {e.tag, " valid/err exclusive"}, int'(valid_o & err_o), 0);
        chk(code_o == e.code, e.is_err ? "R10" : "R6", {e.tag, " code"}, int'(code_o), int'(e.code));
        chk(cyc == e.stamp, "R2", {e.tag, " timing"}, cyc, e.stamp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(code_o == 0 && !valid_o && !err_o, "R1", "in reset", int'(code_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(code_o == 0 && !valid_o && !err_o, "R1", "after reset", int'(code_o), 0);

    run_win("R7 flag2",          5, 20, 8'h04, 0, 0, 8'h00, 20, 0);
    run_win("R7 flag5",          8, 30, 8'h20, 0, 0, 8'h00, 20, 0);
    run_win("R6 prio 1v3",      10, 12, 8'h0A, 0, 0, 8'h00, 20, 0);
    run_win("R7 image pair",    10, 12, 8'h11, 0, 0, 8'h00, 20, 0);
    run_win("R7 image+6",       10, 12, 8'h51, 0, 0, 8'h00, 20, 0);
    run_win("R4 short+exact",   10, N-1, 8'h02, 40, N, 8'h80, 20, 0);
    run_win("R4 split run",     10, N-1, 8'h08, 10+N, N-1, 8'h08, 20, 0);
    run_win("R4 late short",    W-N+2, 50, 8'h01, 0, 0, 8'h00, 20, 0);
    run_win("R4 late exact",    W-N+1, 50, 8'h01, 0, 0, 8'h00, 20, 0);

    // R5: flags while idle are ignored
    @(negedge clk);
    det = 8'hFF;
    repeat (30) @(negedge clk);
    det = '0;
    repeat (4) @(negedge clk);
    run_win("R5 idle flags",     0, 0, 8'h00, 0, 0, 8'h00, 20, 0);
    run_win("R5 after window",   W+1, 2, 8'h04, 0, 0, 8'h00, 20, 0);
    run_win("R3 retrigger",      5, 20, 8'h04, 0, 0, 8'h00, 20, 1);
    run_win("R3 held strobe",   50, 10, 8'h40, 0, 0, 8'h00, W+4, 0);

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R2", "missing results", q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule